// File: doc/BRIEF.md
# Run-Length Bitstream Decompressor

This block turns a stream of one-byte run-length codes into a serial stream of configuration bits, one bit per clock, for a downstream configuration shifter. Code bytes arrive on a ready/valid input with a last marker on the final byte of a stream. Bits leave on a ready/valid output whose last flag marks the end of the stream.

Every code byte falls into one of four ranges. The lowest range gives a run of ones closed by a zero. The next value gives a long run of ones with no closing zero. The range above that gives a run of zeros closed by a one. The top value gives a lone one. In decode mode each stream is preceded by a fixed 16-bit synchronisation pattern. A bypass input sends raw bytes MSB first instead, with no pattern and no decoding. The input takes one code at a time, and output back-pressure pauses expansion without losing any bit.

Top module: `rle_bit_expander`

## Requirements
- R1: In decode mode (bypass_i low), before the first code byte of a stream, the output carries the 16 bits 1111_1111_0010_0000, first bit leftmost. A stream starts after reset and after any byte taken with in_last high.
- R2: A code n with 1 <= n <= 226 produces n one-bits and then one zero-bit.
- R3: Code 227 produces 226 one-bits and no closing zero-bit.
- R4: A code n with 228 <= n <= 254 produces (n - 228) zero-bits and then one one-bit, so code 228 produces a single one-bit.
- R5: Code 255 produces a single one-bit.
- R6: Code 0 in decode mode produces no bits and is consumed at once: when it is taken without in_last, in_ready is high again on the next cycle.
- R7: With bypass_i high, each byte is sent as 8 bits, bit 7 first, with no synchronisation pattern.
- R8: After a byte that produces bits is taken, in_ready stays low on the next cycle. No new byte is taken until the final bit of the current code has entered the output register.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_bit keeps its value. Every produced bit is delivered exactly once, in order.
- R10: out_last is high on the final bit produced by the byte taken with in_last. If that byte is a code 0, out_last is instead raised on the bit still waiting in the output register.
- R11: After reset, out_valid and out_last are low. In decode mode, in_ready is low until the synchronisation pattern has been started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_i | input | 1 | High: send raw bytes; low: decode run-length codes |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Code byte or raw byte |
| in_last | input | 1 | Byte is the final one of its stream |
| in_ready | output | 1 | Block takes the byte this cycle |
| out_valid | output | 1 | Output bit valid |
| out_bit | output | 1 | Serial output bit |
| out_last | output | 1 | Final bit of the stream |
| out_ready | input | 1 | Downstream takes the bit this cycle |

## Verification
A wrong run counter or range decode shows up as a stream of the wrong length or polarity. The bench sees this as a bit mismatch within one code's expansion, at most 227 bits after the faulty byte. If the pending-pattern flag is lost, the first 16 bits of the next decode stream are missing or duplicated. If the last-stream tag is lost, out_last goes missing on the final bit. If the output register drops or repeats a bit under back-pressure, the captured sequence shifts from that point on. A stalled bit that changes is caught on the very next cycle.

// File: rtl/rle_pkg.sv
`timescale 1ns/1ps
package rle_pkg;
  typedef enum logic [1:0] {
    GEN_IDLE  = 2'd0,
    GEN_SHIFT = 2'd1,
    GEN_RUN   = 2'd2
  } gen_mode_t;
endpackage

// File: rtl/rle_code_decode.sv
`timescale 1ns/1ps
module rle_code_decode #(
  parameter int BYTE_W    = 8,
  parameter int RUN_LIMIT = 226,
  parameter int CNT_W     = 9
) (
  input  logic [BYTE_W-1:0] code,
  output logic [CNT_W-1:0]  run_len,
  output logic              run_val,
  output logic              tail_en,
  output logic              tail_val
);
  localparam logic [CNT_W-1:0] LIM     = CNT_W'(RUN_LIMIT);
  localparam logic [CNT_W-1:0] LIM_P1  = CNT_W'(RUN_LIMIT + 1);
  localparam logic [CNT_W-1:0] ZBASE   = CNT_W'(RUN_LIMIT + 2);
  localparam logic [CNT_W-1:0] TOPCODE = CNT_W'((1 << BYTE_W) - 1);

  logic [CNT_W-1:0] c;

  always_comb begin
    c        = CNT_W'(code);
    run_len  = '0;
    run_val  = 1'b0;
    tail_en  = 1'b0;
    tail_val = 1'b0;
    if (c == '0) begin
      tail_en = 1'b0;
    end else if (c <= LIM) begin
      run_len  = c;
      run_val  = 1'b1;
      tail_en  = 1'b1;
      tail_val = 1'b0;
    end else if (c == LIM_P1) begin
      run_len = LIM;
      run_val = 1'b1;
    end else if (c < TOPCODE) begin
      run_len  = c - ZBASE;
      run_val  = 1'b0;
      tail_en  = 1'b1;
      tail_val = 1'b1;
    end else begin
      tail_en  = 1'b1;
      tail_val = 1'b1;
    end
  end
endmodule

// File: rtl/rle_bit_gen.sv
`timescale 1ns/1ps
module rle_bit_gen
  import rle_pkg::*;
#(
  parameter int              BYTE_W  = 8,
  parameter int              HDR_W   = 16,
  parameter logic [HDR_W-1:0] HDR_PAT = 16'hFF20,
  parameter int              CNT_W   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass_i,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic [CNT_W-1:0]  dec_run,
  input  logic              dec_run_val,
  input  logic              dec_tail,
  input  logic              dec_tail_val,
  input  logic              adv,
  output logic              gen_valid,
  output logic              gen_bit,
  output logic              gen_last,
  output logic              tag_last
);
  localparam int SR_W   = (HDR_W > BYTE_W) ? HDR_W : BYTE_W;
  localparam int LEFT_W = $clog2(SR_W + 1);

  gen_mode_t         mode;
  logic [SR_W-1:0]   sreg;
  logic [LEFT_W-1:0] left;
  logic [CNT_W-1:0]  run_left;
  logic              run_val, tail_pend, tail_val;
  logic              code_last, hdr_pend;

  logic idle, need_hdr, take, start_hdr, zero_code, gen_final, step;

  always_comb begin
    idle      = (mode == GEN_IDLE);
    need_hdr  = hdr_pend && !bypass_i;
    in_ready  = idle && !need_hdr;
    take      = in_valid && in_ready;
    start_hdr = idle && need_hdr && in_valid;
    zero_code = !bypass_i && (dec_run == '0) && !dec_tail;
    tag_last  = take && zero_code && in_last;
    gen_valid = !idle;
    step      = gen_valid && adv;
    gen_bit   = 1'b0;
    gen_final = 1'b0;
    if (mode == GEN_SHIFT) begin
      gen_bit   = sreg[SR_W-1];
      gen_final = (left == LEFT_W'(1));
    end else if (mode == GEN_RUN) begin
      gen_bit   = (run_left != '0) ? run_val : tail_val;
      gen_final = (run_left == '0) || ((run_left == CNT_W'(1)) && !tail_pend);
    end
    gen_last = gen_final && code_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= GEN_IDLE;
      sreg      <= '0;
      left      <= '0;
      run_left  <= '0;
      run_val   <= 1'b0;
      tail_pend <= 1'b0;
      tail_val  <= 1'b0;
      code_last <= 1'b0;
      hdr_pend  <= 1'b1;
    end else if (start_hdr) begin
      mode      <= GEN_SHIFT;
      sreg      <= SR_W'(HDR_PAT) << (SR_W - HDR_W);
      left      <= LEFT_W'(HDR_W);
      code_last <= 1'b0;
      hdr_pend  <= 1'b0;
    end else if (take) begin
      code_last <= in_last;
      if (in_last) hdr_pend <= 1'b1;
      if (bypass_i) begin
        mode <= GEN_SHIFT;
        sreg <= SR_W'(in_data) << (SR_W - BYTE_W);
        left <= LEFT_W'(BYTE_W);
      end else if (!zero_code) begin
        mode      <= GEN_RUN;
        run_left  <= dec_run;
        run_val   <= dec_run_val;
        tail_pend <= dec_tail;
        tail_val  <= dec_tail_val;
      end
    end else if (step) begin
      if (mode == GEN_SHIFT) begin
        sreg <= sreg << 1;
        left <= left - LEFT_W'(1);
      end else if (run_left != '0) begin
        run_left <= run_left - CNT_W'(1);
      end else begin
        tail_pend <= 1'b0;
      end
      if (gen_final) mode <= GEN_IDLE;
    end
  end
endmodule

// File: rtl/rle_out_stage.sv
`timescale 1ns/1ps
module rle_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic gen_valid,
  input  logic gen_bit,
  input  logic gen_last,
  input  logic tag_last,
  output logic adv,
  output logic out_valid,
  output logic out_bit,
  output logic out_last,
  input  logic out_ready
);
  logic load;

  always_comb begin
    adv  = !out_valid || out_ready;
    load = gen_valid && adv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_bit   <= gen_bit;
      out_last  <= gen_last;
    end else begin
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
      if (tag_last && out_valid && !out_ready) out_last <= 1'b1;
    end
  end
endmodule

// File: rtl/rle_bit_expander.sv
`timescale 1ns/1ps
module rle_bit_expander #(
  parameter int               BYTE_W    = 8,
  parameter int               RUN_LIMIT = 226,
  parameter int               HDR_W     = 16,
  parameter logic [HDR_W-1:0] HDR_PAT   = 16'hFF20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass_i,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_bit,
  output logic              out_last,
  input  logic              out_ready
);
  localparam int CNT_W = BYTE_W + 1;

  logic [CNT_W-1:0] dec_run;
  logic dec_run_val, dec_tail, dec_tail_val;
  logic adv, gen_valid, gen_bit, gen_last, tag_last;

  rle_code_decode #(
    .BYTE_W(BYTE_W), .RUN_LIMIT(RUN_LIMIT), .CNT_W(CNT_W)
  ) u_dec (
    .code(in_data), .run_len(dec_run), .run_val(dec_run_val),
    .tail_en(dec_tail), .tail_val(dec_tail_val)
  );

  rle_bit_gen #(
    .BYTE_W(BYTE_W), .HDR_W(HDR_W), .HDR_PAT(HDR_PAT), .CNT_W(CNT_W)
  ) u_gen (
    .clk(clk), .rst(rst), .bypass_i(bypass_i),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready),
    .dec_run(dec_run), .dec_run_val(dec_run_val),
    .dec_tail(dec_tail), .dec_tail_val(dec_tail_val),
    .adv(adv), .gen_valid(gen_valid), .gen_bit(gen_bit),
    .gen_last(gen_last), .tag_last(tag_last)
  );

  rle_out_stage u_out (
    .clk(clk), .rst(rst),
    .gen_valid(gen_valid), .gen_bit(gen_bit), .gen_last(gen_last),
    .tag_last(tag_last), .adv(adv),
    .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last),
    .out_ready(out_ready)
  );
endmodule

// File: rtl/rle_bit_expander_chk.sv
`timescale 1ns/1ps
module rle_bit_expander_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bypass_i,
  input logic              in_valid,
  input logic [BYTE_W-1:0] in_data,
  input logic              in_last,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_bit,
  input logic              out_last,
  input logic              out_ready
);
  // R9: a stalled bit holds
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && (out_bit == $past(out_bit)));

  // R8: a bit-producing byte blocks the input on the next cycle
  assert_one_code_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (in_data != '0) |=> !in_ready);

  // R6: code 0 is consumed without blocking
  assert_zero_free_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !bypass_i && (in_data == '0) && !in_last |=> in_ready);

  // R10: the last flag only rides on a valid bit
  assert_last_valid_R10: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R11: nothing valid right after reset
  assert_reset_quiet_R11: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && !out_last);
endmodule

bind rle_bit_expander rle_bit_expander_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .bypass_i(bypass_i), .in_valid(in_valid),
  .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
  .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last),
  .out_ready(out_ready)
);

// File: tb/rle_bit_expander_test.sv
`timescale 1ns/1ps
module rle_bit_expander_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bypass_i = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic       in_last = 1'b0;
  logic       in_ready, out_valid, out_bit, out_last;
  logic       out_ready;

  int checks = 0;
  int fails  = 0;
  int ready_mode = 1;   // 0 low, 1 high, 2 pattern
  int cyc = 0;

  logic cap_bit [0:2047];
  logic cap_lst [0:2047];
  int   cap_n = 0;
  logic exp_bit [0:2047];
  logic exp_lst [0:2047];
  int   exp_n = 0;
  int   stall_bad = 0;
  logic prev_stall = 1'b0;
  logic prev_bit = 1'b0;

  rle_bit_expander uut (
    .clk(clk), .rst(rst), .bypass_i(bypass_i), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_bit(out_bit), .out_last(out_last),
    .out_ready(out_ready)
  );

  always #10 clk = ~clk;

  initial out_ready = 1'b1;
  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    if (ready_mode == 0)      out_ready = 1'b0;
    else if (ready_mode == 1) out_ready = 1'b1;
    else                      out_ready = ((cyc % 5) == 1) || ((cyc % 7) == 3) ? 1'b0 : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall && (!out_valid || out_bit != prev_bit)) stall_bad = stall_bad + 1;
      if (out_valid && out_ready && cap_n < 2048) begin
        cap_bit[cap_n] = out_bit;
        cap_lst[cap_n] = out_last;
        cap_n = cap_n + 1;
      end
      prev_stall = out_valid && !out_ready;
      prev_bit   = out_bit;
    end
  end

  initial begin
    while (cyc < 150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic exp_push(input logic b);
    exp_bit[exp_n] = b;
    exp_lst[exp_n] = 1'b0;
    exp_n = exp_n + 1;
  endtask

  task automatic exp_header();
    for (int i = 15; i >= 0; i--) exp_push(((16'hFF20 >> i) & 16'h1) != 0);
  endtask

  task automatic exp_code(input int n, input logic lst);
    if (n >= 1 && n <= 226) begin
      for (int i = 0; i < n; i++) exp_push(1'b1);
      exp_push(1'b0);
    end else if (n == 227) begin
      for (int i = 0; i < 226; i++) exp_push(1'b1);
    end else if (n >= 228 && n <= 254) begin
      for (int i = 0; i < n - 228; i++) exp_push(1'b0);
      exp_push(1'b1);
    end else if (n == 255) begin
      exp_push(1'b1);
    end
    if (lst && exp_n > 0) exp_lst[exp_n-1] = 1'b1;
  endtask

  task automatic exp_raw(input logic [7:0] d, input logic lst);
    for (int i = 7; i >= 0; i--) exp_push(d[i]);
    if (lst) exp_lst[exp_n-1] = 1'b1;
  endtask

  task automatic start_scn();
    cap_n = 0;
    exp_n = 0;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic lst);
    in_data  = d;
    in_last  = lst;
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_drain();
    int k = 0;
    while (cap_n < exp_n && k < 4000) begin
      @(posedge clk);
      #1;
      k++;
    end
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic check_stream(input string req);
    chk(cap_n == exp_n, {req, " bit count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(cap_bit[i] == exp_bit[i], {req, " bit value"}, int'(cap_bit[i]), int'(exp_bit[i]));
      chk(cap_lst[i] == exp_lst[i], {req, " last flag"}, int'(cap_lst[i]), int'(exp_lst[i]));
    end
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R11 out_valid after reset", int'(out_valid), 0);
    chk(out_last == 1'b0, "R11 out_last after reset", int'(out_last), 0);
    chk(in_ready == 1'b0, "R11 in_ready before header", int'(in_ready), 0);
  endtask

  task automatic t_ones();
    start_scn();
    exp_header();
    exp_code(1, 1'b0); exp_code(5, 1'b0); exp_code(226, 1'b1);
    send_byte(8'd1, 1'b0);
    send_byte(8'd5, 1'b0);
    chk(in_ready == 1'b0, "R8 input held after code", int'(in_ready), 0);
    send_byte(8'd226, 1'b1);
    wait_drain();
    check_stream("R1 R2 R10 ones runs");
  endtask

  task automatic t_max();
    start_scn();
    exp_header();
    exp_code(227, 1'b0); exp_code(2, 1'b1);
    send_byte(8'd227, 1'b0);
    send_byte(8'd2, 1'b1);
    wait_drain();
    check_stream("R3 max ones run");
  endtask

  task automatic t_zeros();
    start_scn();
    exp_header();
    exp_code(228, 1'b0); exp_code(230, 1'b0); exp_code(254, 1'b1);
    send_byte(8'd228, 1'b0);
    send_byte(8'd230, 1'b0);
    send_byte(8'd254, 1'b1);
    wait_drain();
    check_stream("R4 zero runs");
  endtask

  task automatic t_single();
    start_scn();
    exp_header();
    exp_code(255, 1'b0); exp_code(255, 1'b1);
    send_byte(8'd255, 1'b0);
    send_byte(8'd255, 1'b1);
    wait_drain();
    check_stream("R5 lone one");
  endtask

  task automatic t_zero_code();
    start_scn();
    exp_header();
    exp_code(3, 1'b0); exp_code(0, 1'b0); exp_code(0, 1'b0); exp_code(1, 1'b1);
    send_byte(8'd3, 1'b0);
    send_byte(8'd0, 1'b0);
    chk(in_ready == 1'b1, "R6 code 0 consumed at once", int'(in_ready), 1);
    send_byte(8'd0, 1'b0);
    send_byte(8'd1, 1'b1);
    wait_drain();
    check_stream("R6 zero code stream");
  endtask

  task automatic t_bypass();
    start_scn();
    bypass_i = 1'b1;
    exp_raw(8'hA5, 1'b0); exp_raw(8'h3C, 1'b0); exp_raw(8'h00, 1'b1);
    send_byte(8'hA5, 1'b0);
    send_byte(8'h3C, 1'b0);
    send_byte(8'h00, 1'b1);
    wait_drain();
    check_stream("R7 bypass raw bytes");
    bypass_i = 1'b0;
  endtask

  task automatic t_stall();
    start_scn();
    stall_bad = 0;
    ready_mode = 2;
    exp_header();
    exp_code(4, 1'b0); exp_code(229, 1'b0); exp_code(40, 1'b1);
    send_byte(8'd4, 1'b0);
    send_byte(8'd229, 1'b0);
    send_byte(8'd40, 1'b1);
    wait_drain();
    ready_mode = 1;
    repeat (3) @(posedge clk);
    #1;
    check_stream("R9 under back-pressure");
    chk(stall_bad == 0, "R9 stalled bit changed", stall_bad, 0);
  endtask

  task automatic t_last_zero();
    start_scn();
    exp_header();
    exp_code(2, 1'b0);
    send_byte(8'd2, 1'b0);
    wait_drain();
    ready_mode = 0;
    repeat (3) @(posedge clk);
    #1;
    exp_code(255, 1'b0);
    send_byte(8'd255, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    exp_code(0, 1'b1);
    send_byte(8'd0, 1'b1);
    repeat (2) @(posedge clk);
    #1;
    chk(out_last == 1'b1, "R10 held bit tagged by code 0", int'(out_last), 1);
    ready_mode = 1;
    wait_drain();
    check_stream("R10 last on held bit");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    @(posedge clk);
    #1;
    t_ones();
    t_max();
    t_zeros();
    t_single();
    t_zero_code();
    t_bypass();
    t_stall();
    t_last_zero();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule